// File: doc/BRIEF.md
# Gated Multichannel Pulse Shaper

This block turns sixteen already-discriminated hit bits, sampled on a fast clock, into output pulses whose length is set by software. Each channel runs its own small state machine. It has two states, CH_IDLE and CH_ACTIVE, and a down-counter. A trigger in CH_IDLE takes the transition *fire* into CH_ACTIVE. A trigger in CH_ACTIVE takes *retrigger*, which reloads the counter. When the counter reaches zero with no new trigger, the channel takes *expire* back to CH_IDLE. If the channel's enable bit is cleared, it takes *disable*, which drops it to CH_IDLE from either state.

A trigger is a hit on an enabled channel while the global veto is low, or a test strobe. The test strobe comes either from the external test input or from a write to the test address, and it fires every enabled channel at once, whatever the veto. Channels 0–7 share one width code and channels 8–15 share another. The channel outputs are combined into an OR output. A lamp stretcher keeps a front-panel indicator lit after any OR activity. The stretcher has two states: LAMP_DARK moves to LAMP_LIT by *light*, LAMP_LIT reloads its hold counter by *refresh*, and it returns to LAMP_DARK by *fade* once the hold count runs out.

Configuration arrives on a single-cycle write port: an enable, a 2-bit address and a 16-bit data word.

Top module: `hitgate_shaper`

## Requirements
- R1: After reset (active-low `rst_n`), `ch_out`, `or_out` and `lamp_out` are 0, the mask is 0 and both width codes are 0, so hits produce no pulse until the mask is written.
- R2: A hit on an enabled channel, sampled at a rising edge while veto is low, raises that channel's output right after that edge for exactly 2×(w+1) cycles, where w is the group's 8-bit width code (code 0 gives 2 cycles, code 255 gives 512 cycles).
- R3: Address 1 sets the width code (data bits 7:0) for channels 0–7. Address 2 sets it for channels 8–15. Each group's pulses use only their own code.
- R4: Address 0 writes the 16-bit mask, where bit n = 1 enables channel n. Hits on disabled channels produce no pulse. Clearing a bit forces that channel's output low right after the write edge.
- R5: Hits sampled while `veto_in` is high are ignored on every channel. Raising veto during a pulse does not shorten it.
- R6: `test_in` high at a rising edge starts a pulse on every enabled channel right after that edge, even with veto high. Disabled channels stay low.
- R7: A write to address 3 fires every enabled channel one clock after the write edge, and the data value has no effect.
- R8: A trigger on a channel whose pulse is active restarts the full 2×(w+1) count from that edge.
- R9: `or_out` is high exactly when at least one bit of `ch_out` is high.
- R10: `lamp_out` rises one clock after `or_out` is first seen high. It stays high for exactly 2^LAMP_BITS cycles after `or_out` falls, then goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | sampling clock |
| rst_n | input | 1 | asynchronous active-low reset |
| hit_in | input | 16 | discriminated hit per channel |
| veto_in | input | 1 | global veto for hits |
| test_in | input | 1 | external test strobe |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 2 | register address (0 mask, 1 low width, 2 high width, 3 test) |
| wr_data | input | 16 | write data |
| ch_out | output | 16 | shaped channel pulses |
| or_out | output | 1 | OR of all channel outputs |
| lamp_out | output | 1 | stretched OR for an indicator |

## Verification
A hit or an external test strobe sampled at an edge shows on `ch_out` at once after that edge; a test write shows one clock later, after the registered strobe; a mask write takes effect right after its write edge; the lamp follows the OR with one clock of delay. The bench drives inputs on falling edges and samples on the next falling edge, so each check lands half a cycle after the edge at which the result is due. Pulse lengths are measured by counting the falling edges at which a channel is high. The expected counts are computed from 2×(w+1) and 2^LAMP_BITS.

// File: rtl/hitgate_pkg.sv
package hitgate_pkg;
    typedef enum logic {CH_IDLE, CH_ACTIVE} chan_state_e;
    typedef enum logic {LAMP_DARK, LAMP_LIT} lamp_state_e;
    localparam logic [1:0] ADR_MASK = 2'd0;
    localparam logic [1:0] ADR_WLO  = 2'd1;
    localparam logic [1:0] ADR_WHI  = 2'd2;
    localparam logic [1:0] ADR_TEST = 2'd3;
endpackage

// File: rtl/hitgate_cfg.sv
module hitgate_cfg
    import hitgate_pkg::*;
#(
    parameter int NCH = 16,
    parameter int WW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [1:0]     wr_addr,
    input  logic [NCH-1:0] wr_data,
    output logic [NCH-1:0] mask,
    output logic [WW-1:0]  width_lo,
    output logic [WW-1:0]  width_hi,
    output logic           test_strobe
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask        <= '0;
            width_lo    <= '0;
            width_hi    <= '0;
            test_strobe <= 1'b0;
        end else begin
            test_strobe <= wr_en && (wr_addr == ADR_TEST);
            if (wr_en) begin
                unique case (wr_addr)
                    ADR_MASK: mask     <= wr_data;
                    ADR_WLO:  width_lo <= wr_data[WW-1:0];
                    ADR_WHI:  width_hi <= wr_data[WW-1:0];
                    ADR_TEST: ;
                endcase
            end
        end
    end

    p_test_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADR_TEST) |=> test_strobe);
endmodule

// File: rtl/hitgate_chan.sv
module hitgate_chan
    import hitgate_pkg::*;
#(
    parameter int WW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          hit,
    input  logic          veto,
    input  logic          test,
    input  logic [WW-1:0] width,
    output logic          pulse_out
);
    localparam int CW = WW + 1;

    chan_state_e   st, st_n;
    logic [CW-1:0] cnt, cnt_n;
    logic          trig;
    logic [CW-1:0] load;

    assign trig = en & ((hit & ~veto) | test);
    assign load = {width, 1'b1};

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        if (!en) begin
            st_n  = CH_IDLE;
            cnt_n = '0;
        end else begin
            unique case (st)
                CH_IDLE: if (trig) begin
                    st_n  = CH_ACTIVE;
                    cnt_n = load;
                end
                CH_ACTIVE: begin
                    if (trig)           cnt_n = load;
                    else if (cnt == '0) st_n  = CH_IDLE;
                    else                cnt_n = cnt - CW'(1);
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= CH_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    always_comb pulse_out = (st == CH_ACTIVE) && en;

    p_fire_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (st == CH_ACTIVE));
    p_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CH_ACTIVE && en && !trig && cnt != '0) |=> (cnt == $past(cnt) - CW'(1)));
    p_off_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (st == CH_IDLE));
    p_veto_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (veto && !test && st == CH_IDLE) |=> (st == CH_IDLE));
endmodule

// File: rtl/hitgate_lamp.sv
module hitgate_lamp
    import hitgate_pkg::*;
#(
    parameter int LAMP_BITS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic or_in,
    output logic lamp_on
);
    lamp_state_e          st, st_n;
    logic [LAMP_BITS-1:0] cnt, cnt_n;

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        unique case (st)
            LAMP_DARK: if (or_in) begin
                st_n  = LAMP_LIT;
                cnt_n = '1;
            end
            LAMP_LIT: begin
                if (or_in)          cnt_n = '1;
                else if (cnt == '0) st_n  = LAMP_DARK;
                else                cnt_n = cnt - LAMP_BITS'(1);
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= LAMP_DARK;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    always_comb lamp_on = (st == LAMP_LIT);

    p_lamp_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        or_in |=> lamp_on);
    p_lamp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (lamp_on && cnt != '0) |=> lamp_on);
endmodule

// File: rtl/hitgate_shaper.sv
module hitgate_shaper
    import hitgate_pkg::*;
#(
    parameter int NCH       = 16,
    parameter int WW        = 8,
    parameter int LAMP_BITS = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] hit_in,
    input  logic           veto_in,
    input  logic           test_in,
    input  logic           wr_en,
    input  logic [1:0]     wr_addr,
    input  logic [NCH-1:0] wr_data,
    output logic [NCH-1:0] ch_out,
    output logic           or_out,
    output logic           lamp_out
);
    localparam int GRP = NCH / 2;

    logic [NCH-1:0] mask;
    logic [WW-1:0]  width_lo, width_hi;
    logic           test_strobe;
    logic           test_any;

    assign test_any = test_in | test_strobe;

    hitgate_cfg #(.NCH(NCH), .WW(WW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mask(mask), .width_lo(width_lo),
        .width_hi(width_hi), .test_strobe(test_strobe)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic [WW-1:0] w_sel;
        if (i < GRP) begin : g_lo
            assign w_sel = width_lo;
        end else begin : g_hi
            assign w_sel = width_hi;
        end
        hitgate_chan #(.WW(WW)) u_chan (
            .clk(clk), .rst_n(rst_n), .en(mask[i]), .hit(hit_in[i]),
            .veto(veto_in), .test(test_any), .width(w_sel),
            .pulse_out(ch_out[i])
        );
    end

    assign or_out = |ch_out;

    hitgate_lamp #(.LAMP_BITS(LAMP_BITS)) u_lamp (
        .clk(clk), .rst_n(rst_n), .or_in(or_out), .lamp_on(lamp_out)
    );

    p_masked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((ch_out & ~mask) == '0));
    p_test_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
        test_in |=> ((ch_out & mask) == mask));
endmodule

// File: tb/test_hitgate_shaper.sv
module test_hitgate_shaper;
    localparam int NCH = 16;
    localparam int LB  = 6;
    localparam int M   = 1 << LB;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] hit_in = '0;
    logic           veto_in = 1'b0;
    logic           test_in = 1'b0;
    logic           wr_en = 1'b0;
    logic [1:0]     wr_addr = '0;
    logic [NCH-1:0] wr_data = '0;
    logic [NCH-1:0] ch_out;
    logic           or_out, lamp_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    hitgate_shaper #(.NCH(NCH), .WW(8), .LAMP_BITS(LB)) i_hitgate_shaper (
        .clk(clk), .rst_n(rst_n), .hit_in(hit_in), .veto_in(veto_in),
        .test_in(test_in), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ch_out(ch_out), .or_out(or_out),
        .lamp_out(lamp_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic fire(input logic [NCH-1:0] h);
        @(negedge clk);
        hit_in = h;
        @(negedge clk);
        hit_in = '0;
    endtask

    task automatic plen(input int ch, output int n);
        n = 0;
        while (ch_out[ch] && n < 2000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        idle(2);
        chk("R1 ch_out in reset", ch_out, 0);
        chk("R1 or_out in reset", or_out, 0);
        chk("R1 lamp in reset", lamp_out, 0);
        rst_n = 1'b1;
        fire('1);
        chk("R1 zero mask blocks hits", ch_out, 0);
    endtask

    task automatic t_width;
        int n;
        wr(0, 16'hFFFF); wr(1, 16'd3); wr(2, 16'd0);
        fire(16'h0001); plen(0, n); chk("R2 width 3 on ch0", n, 8);
        idle(3);
        fire(16'h0200); plen(9, n); chk("R3 high group code 0", n, 2);
        idle(3);
        wr(1, 16'd10);
        fire(16'h0020); plen(5, n); chk("R3 low group code 10", n, 22);
        idle(3);
        fire(16'h1000); plen(12, n); chk("R3 high group unchanged", n, 2);
        idle(3);
        wr(1, 16'd255);
        fire(16'h0008); plen(3, n); chk("R2 max code 255", n, 512);
        idle(3);
    endtask

    task automatic t_mask;
        wr(1, 16'd10);
        wr(0, 16'hFFF3);
        fire('1);
        chk("R4 mask FFF3 pattern", ch_out, 16'hFFF3);
        idle(30);
        fire(16'h0001);
        chk("R4 ch0 active before clear", ch_out[0], 1);
        wr(0, 16'hFFF2);
        chk("R4 clear forces low", ch_out[0], 0);
        wr(0, 16'hFFFF);
        idle(30);
    endtask

    task automatic t_veto;
        int n;
        wr(1, 16'd3); wr(2, 16'd3);
        @(negedge clk); veto_in = 1'b1;
        fire('1);
        chk("R5 veto blocks hits", ch_out, 0);
        veto_in = 1'b0;
        fire(16'h0001);
        veto_in = 1'b1;
        plen(0, n);
        chk("R5 veto keeps pulse length", n, 8);
        veto_in = 1'b0;
        idle(3);
    endtask

    task automatic t_test_in;
        wr(0, 16'h00F0);
        @(negedge clk); veto_in = 1'b1; test_in = 1'b1;
        @(negedge clk); test_in = 1'b0;
        chk("R6 test bypasses veto, honours mask", ch_out, 16'h00F0);
        veto_in = 1'b0;
        idle(12);
    endtask

    task automatic t_test_wr;
        wr(0, 16'h0F00);
        wr(3, 16'h1234);
        chk("R7 not yet at write edge", ch_out, 0);
        @(negedge clk);
        chk("R7 fires enabled one clock later", ch_out, 16'h0F00);
        chk("R9 or high with pulses", or_out, 1);
        idle(12);
        chk("R9 or low when idle", or_out, 0);
    endtask

    task automatic t_retrig;
        int n;
        wr(0, 16'hFFFF); wr(1, 16'd3);
        @(negedge clk); hit_in = 16'h0002;
        @(negedge clk);
        @(negedge clk); hit_in = 16'h0000;
        plen(1, n);
        chk("R8 retrigger restarts count", n, 8);
        idle(3);
    endtask

    task automatic t_lamp;
        int n;
        idle(M + 16);
        chk("R10 lamp dark after hold", lamp_out, 0);
        wr(1, 16'd0);
        fire(16'h0001);
        chk("R9 or follows pulse", or_out, 1);
        chk("R10 lamp one clock late", lamp_out, 0);
        @(negedge clk);
        chk("R10 lamp lit", lamp_out, 1);
        @(negedge clk);
        chk("R9 or falls with pulse", or_out, 0);
        n = 0;
        while (lamp_out && n < 1000) begin
            n++;
            @(negedge clk);
        end
        chk("R10 lamp hold length", n, M);
    endtask

    initial begin
        t_reset;
        t_width;
        t_mask;
        t_veto;
        t_test_in;
        t_test_wr;
        t_retrig;
        t_lamp;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule